// File: doc/BRIEF.md
# Scanning Channel Sequencer with Result Tagging

This block steps an analog front end through its input channels, one conversion result per channel. It drives the switch-network select for the current channel, lets the digital filter settle on it by discarding early conversions, then raises a one-cycle result strobe with a 3-bit tag naming the channel the result came from, and moves to the next channel. The channel list depends on the input wiring (pseudo-differential against a shared common, or fully differential pairs) and on whether a calibration mode is active. In calibration modes, the offset and gain calibration pairs join the end of the list.

With scanning off, the block holds whatever channel the external select names. It still withholds results until the filter has settled after each change of channel. Once settled, every later conversion on that channel is reported. The settle count is a runtime input: it is the number of conversions thrown away after each switch. The conversion engine and the analog switches are outside the block. The engine's end-of-conversion strobe is the only timing input.

Top module: `scan_seq`

## Requirements
- R1: During and after reset, until the inputs change, `mux_sel` is 0, `cal_pair` is 0, `chan_tag` is 0 and `data_rdy` is 0.
- R2: With scanning on, `diff_sel`=0 and `mode`=00, the channels are visited in the order 0,1,2,3,6 on `mux_sel`. These are inputs 1 to 4 and input 5, each measured against the common input. The tag of each result equals its `mux_sel` code.
- R3: With scanning on, `diff_sel`=1 and `mode`=00, the channels are visited in the order 4,5,6. These are pairs 1-2, 3-4 and 5-6.
- R4: With `mode`=01 or 10, the base list is followed by the offset calibration pair (`mux_sel`=7, `cal_pair`=0) and then by the gain calibration pair (`mux_sel`=7, `cal_pair`=1). Both carry tag 7. `mode`=11 gives the same list as `mode`=00. `cal_pair` is 1 only while `mux_sel` is 7.
- R5: After every channel switch, the first `settle_cnt` strobes on `conv_done` are discarded. The next strobe raises `data_rdy` for exactly one cycle, in the cycle after that strobe.
- R6: Each `data_rdy` carries in `chan_tag` the `mux_sel` value of the cycle in which the accepted strobe arrived. In scan mode, `mux_sel` moves to the next channel in that same cycle.
- R7: After the last channel of the list, the scan wraps to the first channel.
- R8: A change of `scan_en`, `diff_sel` or `mode` (or of `ext_sel` while scanning is off) restarts the sequence. One cycle later, `mux_sel` shows the first channel of the new list. The settle count is cleared. A strobe that arrives in the cycle of the change is discarded.
- R9: With `scan_en`=0, `mux_sel` follows `ext_sel` one cycle later and `cal_pair` is 0. After settling, every accepted strobe produces a `data_rdy` tagged with the held channel.
- R10: With `settle_cnt`=0, every strobe produces a result, and in scan mode every strobe advances the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_en | input | 1 | 1 = scan the channel list automatically |
| diff_sel | input | 1 | 1 = fully differential pairs, 0 = pseudo-differential against the common |
| mode | input | 2 | 00 normal, 01 offset calibration, 10 gain calibration, 11 treated as normal |
| ext_sel | input | 3 | Channel code held when scanning is off |
| conv_done | input | 1 | One-cycle end-of-conversion strobe |
| settle_cnt | input | CNT_W | Conversions discarded after each switch |
| mux_sel | output | 3 | Switch-network channel code |
| cal_pair | output | 1 | With code 7: 0 = offset pair, 1 = gain pair |
| chan_tag | output | 3 | Channel tag of the current result |
| data_rdy | output | 1 | One-cycle result strobe |

## Verification
The bench goes after the wrap from the last channel to the first. A design that forgot the list length would step onto an unused code or stay stuck on the last channel. It changes the configuration in the same cycle as a conversion strobe. A design that counted that strobe, or kept the old settle count, would report a result one conversion too early on the new channel. With a settle count of zero, every strobe must both report and advance; an off-by-one in the settle compare would insert one extra discarded conversion. In hold mode, results must keep coming after settling rather than stop after the first one, and a change of the external select must restart the settling.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

   localparam int CODE_W  = 3;
   localparam int IDX_W   = 3;
   localparam int TBL_N   = 2 ** IDX_W;
   localparam int PSE_LEN = 5;
   localparam int DIF_LEN = 3;

   typedef struct packed {
      logic [CODE_W-1:0] code;
      logic              cal;
   } chan_t;

   typedef struct packed {
      logic              scan;
      logic              diff;
      logic [1:0]        mode;
      logic [CODE_W-1:0] ext;
   } cfg_t;

   function automatic logic cal_active(input logic [1:0] m);
      return (m == 2'b01) || (m == 2'b10);
   endfunction

   function automatic logic [IDX_W-1:0] list_len(input logic d, input logic [1:0] m);
      logic [IDX_W-1:0] n;
      n = d ? IDX_W'(DIF_LEN) : IDX_W'(PSE_LEN);
      if (cal_active(m)) n = n + IDX_W'(2);
      return n;
   endfunction

   function automatic chan_t list_entry(input logic d, input logic [1:0] m,
                                        input logic [IDX_W-1:0] i);
      chan_t            r;
      logic [IDX_W-1:0] base;
      base   = d ? IDX_W'(DIF_LEN) : IDX_W'(PSE_LEN);
      r.code = '0;
      r.cal  = 1'b0;
      if (i < base) begin
         if (d)
            r.code = CODE_W'(3'd4) + CODE_W'(i);
         else if (i == IDX_W'(PSE_LEN - 1))
            r.code = CODE_W'(3'd6);
         else
            r.code = CODE_W'(i);
      end else if (cal_active(m) && (i - base) < IDX_W'(2)) begin
         r.code = CODE_W'(3'd7);
         r.cal  = (i - base) == IDX_W'(1);
      end
      return r;
   endfunction

endpackage

// File: rtl/scan_chan_map.sv
module scan_chan_map
   import scan_seq_pkg::*;
(
   input  logic             diff,
   input  logic [1:0]       mode,
   input  logic [IDX_W-1:0] idx,
   output chan_t            chan,
   output logic             last
);

   chan_t            tbl [TBL_N];
   logic [IDX_W-1:0] len;

   for (genvar g = 0; g < TBL_N; g++) begin : g_entry
      assign tbl[g] = list_entry(diff, mode, IDX_W'(g));
   end

   assign len  = list_len(diff, mode);
   assign chan = tbl[idx];
   assign last = (idx == len - IDX_W'(1));

endmodule

// File: rtl/scan_settle_ctr.sv
module scan_settle_ctr #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             strobe,
   input  logic [CNT_W-1:0] limit,
   output logic             settled
);

   if (CNT_W < 1) begin : g_bad_w
      $error("scan_settle_ctr: CNT_W must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   assign settled = (cnt_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clear)
         cnt_q <= '0;
      else if (strobe && !settled)
         cnt_q <= cnt_q + CNT_W'(1);
   end

endmodule

// File: rtl/scan_seq.sv
module scan_seq
   import scan_seq_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scan_en,
   input  logic             diff_sel,
   input  logic [1:0]       mode,
   input  logic [2:0]       ext_sel,
   input  logic             conv_done,
   input  logic [CNT_W-1:0] settle_cnt,
   output logic [2:0]       mux_sel,
   output logic             cal_pair,
   output logic [2:0]       chan_tag,
   output logic             data_rdy
);

   if (CODE_W != 3) begin : g_bad_code
      $error("scan_seq: channel code must be 3 bits wide");
   end
   if (PSE_LEN + 2 > TBL_N || DIF_LEN + 2 > TBL_N) begin : g_bad_tbl
      $error("scan_seq: list does not fit the index width");
   end

   cfg_t             cfg_now, cfg_q;
   logic [IDX_W-1:0] idx_q;
   chan_t            cur;
   logic             at_last;
   logic             restart, settled, accept, advance;

   assign cfg_now.scan = scan_en;
   assign cfg_now.diff = diff_sel;
   assign cfg_now.mode = mode;
   assign cfg_now.ext  = scan_en ? '0 : ext_sel;

   assign restart = (cfg_now != cfg_q);
   assign accept  = conv_done && settled && !restart;
   assign advance = accept && cfg_q.scan;

   scan_chan_map u_map (
      .diff (cfg_q.diff),
      .mode (cfg_q.mode),
      .idx  (idx_q),
      .chan (cur),
      .last (at_last)
   );

   scan_settle_ctr #(.CNT_W(CNT_W)) u_settle (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (restart || advance),
      .strobe  (conv_done && !restart),
      .limit   (settle_cnt),
      .settled (settled)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q    <= '0;
         idx_q    <= '0;
         chan_tag <= '0;
         data_rdy <= 1'b0;
      end else if (restart) begin
         cfg_q    <= cfg_now;
         idx_q    <= '0;
         data_rdy <= 1'b0;
      end else if (accept) begin
         data_rdy <= 1'b1;
         chan_tag <= mux_sel;
         if (advance)
            idx_q <= at_last ? '0 : idx_q + IDX_W'(1);
      end else begin
         data_rdy <= 1'b0;
      end
   end

   assign mux_sel  = cfg_q.scan ? cur.code : cfg_q.ext;
   assign cal_pair = cfg_q.scan && cur.cal;

endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       scan_en,
   input logic       diff_sel,
   input logic [1:0] mode,
   input logic [2:0] ext_sel,
   input logic       conv_done,
   input logic [2:0] mux_sel,
   input logic       cal_pair,
   input logic [2:0] chan_tag,
   input logic       data_rdy
);

   // R5
   rdy_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_rdy |-> $past(conv_done));

   // R6
   tag_matches_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_rdy |-> chan_tag == $past(mux_sel));

   // R2
   pseudo_list_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_en && !diff_sel && mode == 2'b00 && $stable(scan_en) && $stable(diff_sel)
       && $stable(mode))
      |=> (mux_sel <= 3'd3 || mux_sel == 3'd6));

   // R3
   diff_list_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_en && diff_sel && mode == 2'b00 && $stable(scan_en) && $stable(diff_sel)
       && $stable(mode))
      |=> (mux_sel >= 3'd4 && mux_sel <= 3'd6));

   // R4
   cal_pair_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cal_pair |-> mux_sel == 3'd7);

   // R8
   restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !($stable(scan_en) && $stable(diff_sel) && $stable(mode)) |=> !data_rdy);

   // R9
   hold_follows_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_en |=> (mux_sel == $past(ext_sel) && !cal_pair));

endmodule

bind scan_seq scan_seq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scan_en   (scan_en),
   .diff_sel  (diff_sel),
   .mode      (mode),
   .ext_sel   (ext_sel),
   .conv_done (conv_done),
   .mux_sel   (mux_sel),
   .cal_pair  (cal_pair),
   .chan_tag  (chan_tag),
   .data_rdy  (data_rdy)
);

// File: tb/sim_scan_seq.sv
`timescale 1ns/1ps
module sim_scan_seq;

   localparam int CNT_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             scan_en = 1'b0;
   logic             diff_sel = 1'b0;
   logic [1:0]       mode = 2'b00;
   logic [2:0]       ext_sel = 3'd0;
   logic             conv_done = 1'b0;
   logic [CNT_W-1:0] settle_cnt = 8'd3;
   logic [2:0]       mux_sel;
   logic             cal_pair;
   logic [2:0]       chan_tag;
   logic             data_rdy;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   scan_seq #(.CNT_W(CNT_W)) u0 (
      .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .diff_sel(diff_sel),
      .mode(mode), .ext_sel(ext_sel), .conv_done(conv_done),
      .settle_cnt(settle_cnt), .mux_sel(mux_sel), .cal_pair(cal_pair),
      .chan_tag(chan_tag), .data_rdy(data_rdy)
   );

   // {diff, mode, length, 7 x {code[2:0], cal}} ; entry j at bits 4j+3:4j
   localparam logic [33:0] VEC [5] = '{
      {1'b0, 2'b00, 3'd5, 28'h00C6420},
      {1'b1, 2'b00, 3'd3, 28'h0000CA8},
      {1'b0, 2'b01, 3'd7, 28'hFEC6420},
      {1'b1, 2'b10, 3'd5, 28'h00FECA8},
      {1'b1, 2'b11, 3'd3, 28'h0000CA8}
   };

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic strobe();
      @(negedge clk) conv_done = 1'b1;
      @(negedge clk) conv_done = 1'b0;
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog (R1..): got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 mux in reset", mux_sel, 0);
      chk("R1 rdy in reset", data_rdy, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 mux", mux_sel, 0);
      chk("R1 cal_pair", cal_pair, 0);
      chk("R1 tag", chan_tag, 0);
      chk("R1 rdy", data_rdy, 0);

      // table walk: lists, tags, settling, wrap
      for (int v = 0; v < 5; v++) begin
         logic [33:0] e;
         int len;
         string rq;
         e   = VEC[v];
         len = int'(e[30:28]);
         rq  = (e[32:31] == 2'b01 || e[32:31] == 2'b10) ? "R4" : (e[33] ? "R3" : "R2");
         @(negedge clk);
         scan_en = 1'b1; diff_sel = e[33]; mode = e[32:31]; settle_cnt = 8'd3;
         repeat (2) @(negedge clk);
         chk({rq, " first mux"}, mux_sel, int'(e[3:1]));
         for (int k = 0; k <= len; k++) begin
            int cur, nxt;
            cur = k % len;
            nxt = (k + 1) % len;
            for (int s = 0; s < 3; s++) begin
               strobe();
               chk("R5 discard", data_rdy, 0);
            end
            strobe();
            chk("R5 rdy", data_rdy, 1);
            chk({rq, " R6 tag"}, chan_tag, int'(e[4*cur+1 +: 3]));
            chk({rq, (k == len - 1) ? " R7 wrap mux" : " R6 next mux"},
                mux_sel, int'(e[4*nxt+1 +: 3]));
            chk({rq, " cal_pair"}, cal_pair, int'(e[4*nxt]));
            @(negedge clk);
            chk("R5 one cycle", data_rdy, 0);
         end
      end

      // R10: zero settle count
      @(negedge clk);
      scan_en = 1'b1; diff_sel = 1'b0; mode = 2'b00; settle_cnt = 8'd0;
      repeat (2) @(negedge clk);
      for (int k = 0; k < 6; k++) begin
         int exp_t;
         exp_t = (k == 4) ? 6 : (k % 5);
         strobe();
         chk("R10 rdy", data_rdy, 1);
         chk("R10 tag", chan_tag, exp_t);
      end

      // R8: change in the same cycle as a strobe
      @(negedge clk);
      diff_sel = 1'b1; settle_cnt = 8'd3;
      repeat (2) @(negedge clk);
      chk("R8 diff first", mux_sel, 4);
      strobe();
      chk("R8 pre discard", data_rdy, 0);
      @(negedge clk);
      diff_sel = 1'b0; conv_done = 1'b1;
      @(negedge clk);
      conv_done = 1'b0;
      chk("R8 no rdy on change", data_rdy, 0);
      chk("R8 restart mux", mux_sel, 0);
      for (int s = 0; s < 3; s++) begin
         strobe();
         chk("R8 count cleared", data_rdy, 0);
      end
      strobe();
      chk("R8 rdy after settle", data_rdy, 1);
      chk("R8 tag", chan_tag, 0);

      // R9: hold mode
      @(negedge clk);
      scan_en = 1'b0; ext_sel = 3'd5;
      @(negedge clk);
      chk("R9 mux follows ext", mux_sel, 5);
      chk("R9 cal_pair", cal_pair, 0);
      for (int s = 0; s < 3; s++) begin
         strobe();
         chk("R9 discard", data_rdy, 0);
      end
      for (int r = 0; r < 3; r++) begin
         strobe();
         chk("R9 rdy", data_rdy, 1);
         chk("R9 tag", chan_tag, 5);
         chk("R9 mux held", mux_sel, 5);
      end
      @(negedge clk);
      ext_sel = 3'd2;
      @(negedge clk);
      chk("R9 new ext", mux_sel, 2);
      strobe();
      chk("R9 resettle", data_rdy, 0);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule